// File: doc/BRIEF.md
# Dual 32-bit CAN Identifier Acceptance Filter

This block decides whether a frame that has just finished arriving in the receive buffer is kept. The receiver presents the four-byte packed identifier image of the frame together with a one-cycle completion pulse. The block compares that image against two programmable 32-bit filters. Each filter has four code bytes and four mask bytes. If a filter matches, the block raises a receive-full flag and records which filter matched. If no filter matches, nothing changes, and the receiver may reuse the buffer for the next frame.

A byte-wide host port reads and writes the code bytes, the mask bytes, a control byte and a status byte. The control byte holds the filter mode and shows the hit index. The status byte holds the receive-full and overrun flags. Each flag is cleared by writing 1 to its bit. The packed image puts identifier bits 28..21 in byte 0 (frame_id[31:24]). Byte 1 carries ID20..18, SRR, IDE and ID17..15, from MSB to LSB. Byte 2 carries ID14..7. Byte 3 carries ID6..0 in bits 7:1 and RTR in bit 0. For example, identifier 0x00BEEF1A with SRR=1, IDE=1 and RTR=0 packs to 0x05FDDE34. The comparison covers all 32 image bits, so SRR, IDE and RTR are compared like any identifier bit. When standard identifiers are received in this mode, the host must set the three low bits of mask bytes 1 and 5 to don't care.

Top module: `canid_accept_filter`

## Requirements
- R1: After reset, every code byte, every mask byte, the mode field, the hit field, receive-full and overrun all read as 0.
- R2: Host addresses 0..7 are code bytes 0..7 and addresses 8..15 are mask bytes 0..7; each reads back the value last written. Address 16 is the control byte: bits 1:0 are the mode (read/write), bits 6:4 are the hit index (read-only), all other bits read 0. Address 17 is the status byte: bit 0 is receive-full, bit 1 is overrun. reg_rdata follows reg_addr combinationally.
- R3: Filter 0 uses code/mask bytes 0..3 and filter 1 uses bytes 4..7. Byte 4k+j is compared against image byte j, where image byte 0 is frame_id[31:24] and image byte 3 is frame_id[7:0].
- R4: A mask bit of 0 requires the image bit to equal the code bit. A mask bit of 1 makes that bit position don't care.
- R5: When only filter 0 accepts, the hit field becomes 3'b000. When only filter 1 accepts, it becomes 3'b001.
- R6: When both filters accept the same frame, filter 0 wins and the hit field becomes 3'b000.
- R7: An accepted frame sets receive-full on the clock edge that samples frame_done high. A rejected frame leaves receive-full, overrun and the hit field unchanged.
- R8: Writing a 1 to status bit 0 clears receive-full, and writing a 1 to status bit 1 clears overrun. Writing a 0 to either bit leaves that flag unchanged.
- R9: A frame that is accepted while receive-full is set (after any clear in the same cycle has taken effect) sets overrun and leaves the hit field unchanged.
- R10: Only mode 2'b00 (two 32-bit filters) accepts frames. With any other mode value, every frame is rejected.
- R11: While frame_done is low, changes on frame_id do not affect any flag or the hit field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Host write strobe |
| reg_addr | input | 5 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for reg_addr |
| frame_done | input | 1 | One-cycle pulse: the frame in the receive buffer is complete |
| frame_id | input | 32 | Packed identifier image of the completed frame |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Accepted frame arrived while receive-full was set |
| hit_idx | output | 3 | Index of the filter that accepted the last kept frame |

## Verification
The properties assume that frame_done is a single-cycle pulse that is sampled together with a stable frame_id. They also assume that a host write to the status byte is the only way a flag falls. A clear written in the same cycle as a completion pulse is excluded from the clear-property antecedent. The stimulus always separates writes and frame pulses into different cycles, each driven on the falling edge, so every checked cycle has exactly one cause. Filter contents change only between frames, which matches how a host reprograms filters while the receiver is idle.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
   localparam int unsigned CF_BYTE_W = 8;
   localparam int unsigned CF_HIT_W  = 3;

   typedef enum logic [1:0] {
      FMODE_DUAL32 = 2'b00,
      FMODE_QUAD16 = 2'b01,
      FMODE_OCT8   = 2'b10,
      FMODE_CLOSED = 2'b11
   } fmode_e;

   typedef struct packed {
      logic                full;
      logic                ovr;
      logic [CF_HIT_W-1:0] hit;
   } rxstat_t;
endpackage

// File: rtl/canid_match.sv
module canid_match #(
   parameter int unsigned ID_W = 32
) (
   input  logic [ID_W-1:0] id_img,
   input  logic [ID_W-1:0] code,
   input  logic [ID_W-1:0] mask,
   output logic            match
);
   // Bits that differ and are not masked out make the filter miss.
   logic [ID_W-1:0] diff;
   assign diff  = (id_img ^ code) & ~mask;
   assign match = (diff == '0);
endmodule

// File: rtl/canid_regs.sv
module canid_regs
   import can_filt_pkg::*;
#(
   parameter int unsigned NBYTES    = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned MASK_BASE = 8,
   parameter int unsigned CTRL_ADDR = 16,
   parameter int unsigned STAT_ADDR = 17
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wen,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [CF_BYTE_W-1:0]        wdata,
   output logic [NBYTES*CF_BYTE_W-1:0] code_flat,
   output logic [NBYTES*CF_BYTE_W-1:0] mask_flat,
   output fmode_e                      mode,
   output logic                        clr_full,
   output logic                        clr_ovr
);
   localparam int unsigned FLAT_W = NBYTES * CF_BYTE_W;

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic [CF_BYTE_W-1:0] code_q, mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
         end else if (wen) begin
            if (addr == ADDR_W'(i))             code_q <= wdata;
            if (addr == ADDR_W'(MASK_BASE + i)) mask_q <= wdata;
         end
      end
      // byte 0 sits in the most significant position
      assign code_flat[FLAT_W-1-i*CF_BYTE_W -: CF_BYTE_W] = code_q;
      assign mask_flat[FLAT_W-1-i*CF_BYTE_W -: CF_BYTE_W] = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mode <= FMODE_DUAL32;
      else if (wen && addr == ADDR_W'(CTRL_ADDR)) mode <= fmode_e'(wdata[1:0]);
   end

   assign clr_full = wen && (addr == ADDR_W'(STAT_ADDR)) && wdata[0];
   assign clr_ovr  = wen && (addr == ADDR_W'(STAT_ADDR)) && wdata[1];
endmodule

// File: rtl/canid_status.sv
module canid_status
   import can_filt_pkg::*;
#(
   parameter int unsigned NUM_FILT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_done,
   input  logic                mode_ok,
   input  logic [NUM_FILT-1:0] hits,
   input  logic                clr_full,
   input  logic                clr_ovr,
   output rxstat_t             stat
);
   logic [CF_HIT_W-1:0] win_idx;
   logic                any_hit, accept, full_eff;

   // Lowest filter index wins.
   always_comb begin
      win_idx = '0;
      for (int k = NUM_FILT - 1; k >= 0; k--)
         if (hits[k]) win_idx = CF_HIT_W'(k);
   end

   assign any_hit  = |hits;
   assign accept   = frame_done && mode_ok && any_hit;
   assign full_eff = stat.full && !clr_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
      end else begin
         stat.full <= full_eff || accept;
         stat.ovr  <= (stat.ovr && !clr_ovr) || (accept && full_eff);
         if (accept && !full_eff) stat.hit <= win_idx;
      end
   end
endmodule

// File: rtl/canid_accept_filter.sv
module canid_accept_filter
   import can_filt_pkg::*;
#(
   parameter int unsigned NUM_FILT = 2,
   parameter int unsigned ID_BYTES = 4,
   parameter int unsigned ADDR_W   = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wen,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [7:0]           reg_wdata,
   output logic [7:0]           reg_rdata,
   input  logic                 frame_done,
   input  logic [ID_BYTES*8-1:0] frame_id,
   output logic                 rx_full,
   output logic                 overrun,
   output logic [2:0]           hit_idx
);
   localparam int unsigned ID_W      = ID_BYTES * CF_BYTE_W;
   localparam int unsigned NBYTES    = NUM_FILT * ID_BYTES;
   localparam int unsigned MASK_BASE = NBYTES;
   localparam int unsigned CTRL_ADDR = 2 * NBYTES;
   localparam int unsigned STAT_ADDR = CTRL_ADDR + 1;
   localparam int unsigned FLAT_W    = NBYTES * CF_BYTE_W;

   if (NUM_FILT < 1 || NUM_FILT > (1 << CF_HIT_W)) begin : g_bad_filt
      $error("NUM_FILT out of range for the hit field");
   end
   if (STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [FLAT_W-1:0]   code_flat, mask_flat;
   fmode_e              mode;
   logic                clr_full, clr_ovr, mode_ok;
   logic [NUM_FILT-1:0] hits;
   rxstat_t             stat;

   canid_regs #(
      .NBYTES(NBYTES), .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE),
      .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
      .code_flat(code_flat), .mask_flat(mask_flat), .mode(mode),
      .clr_full(clr_full), .clr_ovr(clr_ovr)
   );

   for (genvar k = 0; k < NUM_FILT; k++) begin : g_filt
      canid_match #(.ID_W(ID_W)) u_match (
         .id_img(frame_id),
         .code  (code_flat[FLAT_W-1-k*ID_W -: ID_W]),
         .mask  (mask_flat[FLAT_W-1-k*ID_W -: ID_W]),
         .match (hits[k])
      );
   end

   assign mode_ok = (mode == FMODE_DUAL32);

   canid_status #(.NUM_FILT(NUM_FILT)) u_stat (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .mode_ok(mode_ok),
      .hits(hits), .clr_full(clr_full), .clr_ovr(clr_ovr), .stat(stat)
   );

   assign rx_full = stat.full;
   assign overrun = stat.ovr;
   assign hit_idx = stat.hit;

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (reg_addr == ADDR_W'(i))
            reg_rdata = code_flat[FLAT_W-1-i*CF_BYTE_W -: CF_BYTE_W];
         if (reg_addr == ADDR_W'(MASK_BASE + i))
            reg_rdata = mask_flat[FLAT_W-1-i*CF_BYTE_W -: CF_BYTE_W];
      end
      if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata = {1'b0, stat.hit, 2'b00, mode};
      if (reg_addr == ADDR_W'(STAT_ADDR)) reg_rdata = {6'b0, stat.ovr, stat.full};
   end
endmodule

// File: rtl/canid_accept_filter_chk.sv
module canid_accept_filter_chk #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned STAT_ADDR = 17,
   parameter int unsigned NUM_FILT  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_done,
   input logic              reg_wen,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              rx_full,
   input logic              overrun,
   input logic [2:0]        hit_idx,
   input logic              mode_ok
);
   logic stat_wr;
   assign stat_wr = reg_wen && (reg_addr == ADDR_W'(STAT_ADDR));

   // R7: receive-full only rises after a completion pulse
   p_full_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(frame_done));

   // R9: overrun only rises on a completion while full
   p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> ($past(frame_done) && $past(rx_full)));

   // R9: hit index frozen while the flag stays up
   p_hit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && $past(rx_full)) |-> $stable(hit_idx));

   // R8: writing 1 clears receive-full
   p_w1c_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stat_wr && reg_wdata[0] && !frame_done) |-> !rx_full);

   // R8: writing 0 keeps receive-full
   p_w0_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_wr && !reg_wdata[0]) && $past(rx_full)) |-> rx_full);

   // R10: no acceptance outside dual-32 mode
   p_mode_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!mode_ok) && !$past(rx_full)) |-> !rx_full);

   // R5: hit index names an existing filter
   p_hit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> (32'(hit_idx) < NUM_FILT));
endmodule

bind canid_accept_filter canid_accept_filter_chk #(
   .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .NUM_FILT(NUM_FILT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .reg_wen(reg_wen),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rx_full(rx_full),
   .overrun(overrun), .hit_idx(hit_idx), .mode_ok(mode_ok)
);

// File: tb/canid_accept_filter_tb.sv
module canid_accept_filter_tb;
   localparam int CLK_P = 8;

   logic        clk = 0, rst_n = 0;
   logic        reg_wen = 0;
   logic [4:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        frame_done = 0;
   logic [31:0] frame_id = '0;
   logic        rx_full, overrun;
   logic [2:0]  hit_idx;

   always #(CLK_P/2) clk = ~clk;

   canid_accept_filter u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_done(frame_done),
      .frame_id(frame_id), .rx_full(rx_full), .overrun(overrun), .hit_idx(hit_idx)
   );

   // reference model state
   logic [7:0] code_m [8];
   logic [7:0] mask_m [8];
   logic [1:0] mode_m;
   logic       full_m, ovr_m;
   logic [2:0] hit_m;

   int    n_cmp = 0, n_bad = 0;
   bit    done = 0;
   string       tag_q[$];
   logic [12:0] exp_q[$];
   event        mon_ev;

   function automatic logic [7:0] mdl_rd(input logic [4:0] a);
      if (a < 8)       return code_m[a];
      else if (a < 16) return mask_m[a-8];
      else if (a == 16) return {1'b0, hit_m, 2'b00, mode_m};
      else if (a == 17) return {6'b0, ovr_m, full_m};
      else return 8'h00;
   endfunction

   function automatic bit mdl_match(input int k, input logic [31:0] id);
      logic [31:0] c, m;
      c = {code_m[4*k], code_m[4*k+1], code_m[4*k+2], code_m[4*k+3]};
      m = {mask_m[4*k], mask_m[4*k+1], mask_m[4*k+2], mask_m[4*k+3]};
      return ((id ^ c) & ~m) == 32'h0;
   endfunction

   // monitor: pops expected items and compares with the ports
   always begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
         string       t;
         logic [12:0] e, got;
         t   = tag_q.pop_front();
         e   = exp_q.pop_front();
         got = {reg_rdata, overrun, rx_full, hit_idx};
         n_cmp++;
         if (got !== e) begin
            n_bad++;
            $display("FAIL %s: got rdata=%02h ovr=%0b full=%0b hit=%0d exp rdata=%02h ovr=%0b full=%0b hit=%0d",
                     t, got[12:5], got[4], got[3], got[2:0], e[12:5], e[4], e[3], e[2:0]);
         end
      end
   end

   task automatic chk(input string t, input logic [4:0] a);
      reg_addr = a;
      #1;
      tag_q.push_back(t);
      exp_q.push_back({mdl_rd(a), ovr_m, full_m, hit_m});
      ->mon_ev;
      #1;
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wen = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 0;
      if (a < 8)        code_m[a] = d;
      else if (a < 16)  mask_m[a-8] = d;
      else if (a == 16) mode_m = d[1:0];
      else if (a == 17) begin
         if (d[0]) full_m = 0;
         if (d[1]) ovr_m = 0;
      end
   endtask

   task automatic frame(input logic [31:0] id);
      bit m0, m1;
      @(negedge clk);
      frame_done = 1; frame_id = id;
      @(negedge clk);
      frame_done = 0;
      m0 = mdl_match(0, id);
      m1 = mdl_match(1, id);
      if (mode_m == 2'b00 && (m0 || m1)) begin
         if (full_m) ovr_m = 1;
         else begin
            full_m = 1;
            hit_m  = m0 ? 3'd0 : 3'd1;
         end
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin code_m[i] = 0; mask_m[i] = 0; end
      mode_m = 0; full_m = 0; ovr_m = 0; hit_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctrl", 5'd16);
      chk("R1 status", 5'd17);
      chk("R1 code0", 5'd0);
      chk("R1 mask7", 5'd15);

      // R2 program filters: 0x05FDDE34 and 0x05FDDE42
      wr(0, 8'h05); wr(1, 8'hFD); wr(2, 8'hDE); wr(3, 8'h34);
      wr(4, 8'h05); wr(5, 8'hFD); wr(6, 8'hDE); wr(7, 8'h42);
      chk("R2 code3", 5'd3);
      chk("R2 code7", 5'd7);
      wr(12, 8'hA5);
      chk("R2 mask4", 5'd12);
      wr(12, 8'h00);
      wr(16, 8'h70); // hit bits read-only
      chk("R2 ctrl ro hit", 5'd16);

      // R11 frame_id change without pulse
      @(negedge clk); frame_id = 32'h05FDDE34;
      @(negedge clk);
      chk("R11 no pulse", 5'd17);

      // R5 R3 filter 1 only
      frame(32'h05FDDE42);
      chk("R5 hit filter1", 5'd16);
      chk("R7 full set", 5'd17);

      // R9 overrun, hit held
      frame(32'h05FDDE34);
      chk("R9 overrun hit held", 5'd16);
      chk("R9 overrun flag", 5'd17);

      // R8 write-one-to-clear
      wr(17, 8'h00);
      chk("R8 zero write", 5'd17);
      wr(17, 8'h01);
      chk("R8 clear full", 5'd17);
      wr(17, 8'h02);
      chk("R8 clear overrun", 5'd17);

      // R3 R7 rejected frames: RTR bit and byte 0 differ
      frame(32'h05FDDE35);
      chk("R3 rtr bit reject", 5'd17);
      frame(32'h15FDDE34);
      chk("R3 byte0 reject", 5'd16);

      // R5 filter 0 only
      frame(32'h05FDDE34);
      chk("R5 hit filter0", 5'd16);
      wr(17, 8'h03);

      // R4 R6 masking makes both filters hit
      wr(11, 8'h7E);
      frame(32'h05FDDE42);
      chk("R6 both hit prio", 5'd16);
      chk("R4 mask dont care", 5'd17);
      wr(17, 8'h01);
      frame(32'h05FDDE43);
      chk("R4 unmasked bit reject", 5'd17);

      // R10 other modes reject
      wr(16, 8'h01);
      frame(32'h05FDDE34);
      chk("R10 mode01 reject", 5'd17);
      wr(16, 8'h03);
      frame(32'h05FDDE34);
      chk("R10 mode11 reject", 5'd16);
      wr(16, 8'h00);
      frame(32'h05FDDE34);
      chk("R10 mode00 accept", 5'd17);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule